// File: doc/BRIEF.md
# Two-Bit Branch Predictor with Target Cache

This block sits in the fetch stage of a pipelined processor. Each cycle it takes the fetch address and, with no clock delay, returns three things: a direction guess, a flag that says whether a small tagged cache of branch targets holds this address, and the target stored there. It also returns the next fetch address. Fetch jumps to the cached target only when the cache hits and the guess is taken. In every other case fetch goes on to the next sequential word. A branch that is taken but misses the cache therefore loses one cycle while its target is computed further down the pipe.

When a branch resolves later in the pipe, the pipeline presents the real outcome, the real target and what fetch actually did for that branch. The block raises a misprediction flag in that same cycle so the pipeline can flush. At the next clock edge it updates the direction counter for that address. A taken branch also writes its target into the cache. The direction counter is a four-state machine: STRONG_NT (00), WEAK_NT (01), WEAK_T (10) and STRONG_T (11). A taken outcome moves the counter one state toward STRONG_T, and a not-taken outcome moves it one state toward STRONG_NT. Both end states hold when pushed further outward. Because of this hysteresis, a loop-closing branch that is usually taken costs one misprediction at each loop exit instead of two.

The resolve logic sorts every cycle into one of four classes: IDLE (nothing resolving), CORRECT, DIR_MISS (the taken/redirect decision was wrong) and TGT_MISS (the redirect happened but went to the wrong address).

Top module: `bpred_top`

## Requirements
- R1: After reset every counter is WEAK_NT (01) and every cache entry is invalid, so any lookup gives lk_taken=0, lk_hit=0 and lk_next_pc=lk_pc+4.
- R2: A resolved taken outcome moves the addressed counter one state up (00→01→10→11), and it stays at 11 when already there.
- R3: A resolved not-taken outcome moves the addressed counter one state down (11→10→01→00), and it stays at 00 when already there.
- R4: lk_taken is 1 exactly when the counter is WEAK_T or STRONG_T. Starting from STRONG_T, the guess turns to not-taken only after two not-taken outcomes in a row.
- R5: The counter table is indexed by PC bits [2 +: PHT_IDX_W]. Two addresses that agree in those bits share one counter.
- R6: The target cache is indexed by PC bits [2 +: BTB_IDX_W] and tagged with PC bits [31 : 2+BTB_IDX_W]. lk_hit needs a valid entry with a matching tag. Fetch and resolve addresses are word aligned (bits [1:0] are 0).
- R7: A resolved taken branch writes valid, tag and target into its cache entry. A resolved not-taken branch leaves the cache unchanged.
- R8: lk_next_pc equals lk_target when lk_hit and lk_taken are both 1, and equals lk_pc+4 otherwise.
- R9: rs_mispredict is 1 in the resolve cycle exactly when rs_valid is 1 and either rs_taken differs from rs_pred_redirect, or both are 1 and rs_pred_target differs from rs_target. It is 0 whenever rs_valid is 0.
- R10: A resolve takes effect from the clock edge that ends its cycle. A lookup of the same entry in that same cycle still sees the old counter and cache contents.
- R11: Over a nested-loop outcome pattern, the number of mispredictions flagged matches a two-bit counter reference model.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | 32 | Fetch address being looked up |
| lk_taken | output | 1 | Direction guess for lk_pc |
| lk_hit | output | 1 | Target cache holds lk_pc |
| lk_target | output | 32 | Cached target for lk_pc |
| lk_next_pc | output | 32 | Next fetch address |
| rs_valid | input | 1 | A branch resolves this cycle |
| rs_pc | input | 32 | Address of the resolving branch |
| rs_taken | input | 1 | Actual outcome |
| rs_target | input | 32 | Actual target |
| rs_pred_redirect | input | 1 | Fetch redirected for this branch |
| rs_pred_target | input | 32 | Address fetch redirected to |
| rs_mispredict | output | 1 | Flush request for this resolve |

## Verification
Lookup results and the misprediction flag are combinational. They are valid in the cycle their inputs are applied. A resolve changes the tables only at the next rising edge, so its effect first shows in the cycle after. The bench drives every input on the falling edge and samples outputs 1 ns later, still before the next rising edge. To check an update, it samples the misprediction flag while the resolve is held and samples lookups after the edge that commits it. The same-cycle case is checked by sampling a lookup of the entry being written both before and after that edge.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

    // Two-bit direction counter states
    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_state_t;

    localparam ctr_state_t CTR_RESET = CTR_WEAK_NT;

    // Classification of a resolve cycle
    typedef enum logic [1:0] {
        RES_IDLE     = 2'b00,
        RES_CORRECT  = 2'b01,
        RES_DIR_MISS = 2'b10,
        RES_TGT_MISS = 2'b11
    } res_class_t;

    function automatic logic ctr_says_taken(input ctr_state_t s);
        logic t;
        unique case (s)
            CTR_STRONG_NT, CTR_WEAK_NT: t = 1'b0;
            CTR_WEAK_T, CTR_STRONG_T:   t = 1'b1;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/bpred_pht.sv
module bpred_pht
    import bpred_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_state_t       rd_state,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);

    localparam int DEPTH = 1 << IDX_W;

    ctr_state_t tbl [DEPTH];
    ctr_state_t wr_cur;
    ctr_state_t wr_nxt;

    always_comb wr_cur = tbl[wr_idx];

    // Next-state logic of the addressed counter
    always_comb begin : ctr_next
        wr_nxt = wr_cur;
        unique case (wr_cur)
            CTR_STRONG_NT: wr_nxt = wr_taken ? CTR_WEAK_NT  : CTR_STRONG_NT;
            CTR_WEAK_NT:   wr_nxt = wr_taken ? CTR_WEAK_T   : CTR_STRONG_NT;
            CTR_WEAK_T:    wr_nxt = wr_taken ? CTR_STRONG_T : CTR_WEAK_NT;
            CTR_STRONG_T:  wr_nxt = wr_taken ? CTR_STRONG_T : CTR_WEAK_T;
        endcase
    end

    // State register array
    always_ff @(posedge clk) begin : ctr_regs
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                tbl[i] <= CTR_RESET;
            end
        end else if (wr_en) begin
            tbl[wr_idx] <= wr_nxt;
        end
    end

    // Output process
    always_comb rd_state = tbl[rd_idx];

    AST_PHT_UP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken) |=> ((tbl[$past(wr_idx)] >= $past(wr_cur)) &&
                                 (2'(tbl[$past(wr_idx)] - $past(wr_cur)) <= 2'd1))); // R2
    AST_PHT_SAT_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && wr_cur == CTR_STRONG_T) |=> (tbl[$past(wr_idx)] == CTR_STRONG_T)); // R2
    AST_PHT_DOWN_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken) |=> ((tbl[$past(wr_idx)] <= $past(wr_cur)) &&
                                  (2'($past(wr_cur) - tbl[$past(wr_idx)]) <= 2'd1))); // R3
    AST_PHT_SAT_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && wr_cur == CTR_STRONG_NT) |=> (tbl[$past(wr_idx)] == CTR_STRONG_NT)); // R3

endmodule

// File: rtl/bpred_btb.sv
module bpred_btb #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 26,
    parameter int PC_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_hit,
    output logic [PC_W-1:0]  rd_target,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PC_W-1:0]  wr_target
);

    localparam int DEPTH = 1 << IDX_W;

    logic             vld_q [DEPTH];
    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [PC_W-1:0]  tgt_q [DEPTH];

    always_ff @(posedge clk) begin : vld_regs
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                vld_q[i] <= 1'b0;
            end
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin : data_regs
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            tgt_q[wr_idx] <= wr_target;
        end
    end

    always_comb begin : lookup
        rd_hit    = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
        rd_target = tgt_q[rd_idx];
    end

    AST_BTB_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (vld_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag) &&
                   tgt_q[$past(wr_idx)] == $past(wr_target))); // R7
    AST_BTB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(rd_hit) || $changed(rd_idx) || $changed(rd_tag))); // R7

endmodule

// File: rtl/bpred_resolve.sv
module bpred_resolve
    import bpred_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rs_valid,
    input  logic            rs_taken,
    input  logic [PC_W-1:0] rs_target,
    input  logic            rs_pred_redirect,
    input  logic [PC_W-1:0] rs_pred_target,
    output res_class_t      res_class,
    output logic            mispredict,
    output logic            pht_we,
    output logic            btb_we
);

    always_comb begin : classify
        if (!rs_valid) begin
            res_class = RES_IDLE;
        end else if (rs_taken != rs_pred_redirect) begin
            res_class = RES_DIR_MISS;
        end else if (rs_taken && (rs_pred_target != rs_target)) begin
            res_class = RES_TGT_MISS;
        end else begin
            res_class = RES_CORRECT;
        end
    end

    always_comb begin : outputs
        mispredict = 1'b0;
        pht_we     = 1'b0;
        btb_we     = 1'b0;
        unique case (res_class)
            RES_IDLE: ;
            RES_CORRECT: begin
                pht_we = 1'b1;
                btb_we = rs_taken;
            end
            RES_DIR_MISS, RES_TGT_MISS: begin
                mispredict = 1'b1;
                pht_we     = 1'b1;
                btb_we     = rs_taken;
            end
        endcase
    end

    AST_MISP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rs_valid |-> !mispredict); // R9
    AST_MISP_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && rs_taken != rs_pred_redirect) |-> mispredict); // R9
    AST_NT_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        !rs_taken |-> !btb_we); // R7

endmodule

// File: rtl/bpred_top.sv
module bpred_top
    import bpred_pkg::*;
#(
    parameter int PC_W      = 32,
    parameter int PHT_IDX_W = 6,
    parameter int BTB_IDX_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    output logic            lk_hit,
    output logic [PC_W-1:0] lk_target,
    output logic [PC_W-1:0] lk_next_pc,
    input  logic            rs_valid,
    input  logic [PC_W-1:0] rs_pc,
    input  logic            rs_taken,
    input  logic [PC_W-1:0] rs_target,
    input  logic            rs_pred_redirect,
    input  logic [PC_W-1:0] rs_pred_target,
    output logic            rs_mispredict
);

    localparam int WORD_LSB  = 2;
    localparam int TAG_LSB   = WORD_LSB + BTB_IDX_W;
    localparam int BTB_TAG_W = PC_W - TAG_LSB;

    ctr_state_t           lk_state;
    res_class_t           res_class;
    logic                 pht_we;
    logic                 btb_we;
    logic [PHT_IDX_W-1:0] lk_pht_idx, rs_pht_idx;
    logic [BTB_IDX_W-1:0] lk_btb_idx, rs_btb_idx;
    logic [BTB_TAG_W-1:0] lk_tag, rs_tag;

    always_comb begin : addr_split
        lk_pht_idx = lk_pc[WORD_LSB +: PHT_IDX_W];
        rs_pht_idx = rs_pc[WORD_LSB +: PHT_IDX_W];
        lk_btb_idx = lk_pc[WORD_LSB +: BTB_IDX_W];
        rs_btb_idx = rs_pc[WORD_LSB +: BTB_IDX_W];
        lk_tag     = lk_pc[PC_W-1:TAG_LSB];
        rs_tag     = rs_pc[PC_W-1:TAG_LSB];
    end

    bpred_pht #(.IDX_W(PHT_IDX_W)) u_pht (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lk_pht_idx),
        .rd_state (lk_state),
        .wr_en    (pht_we),
        .wr_idx   (rs_pht_idx),
        .wr_taken (rs_taken)
    );

    bpred_btb #(.IDX_W(BTB_IDX_W), .TAG_W(BTB_TAG_W), .PC_W(PC_W)) u_btb (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (lk_btb_idx),
        .rd_tag    (lk_tag),
        .rd_hit    (lk_hit),
        .rd_target (lk_target),
        .wr_en     (btb_we),
        .wr_idx    (rs_btb_idx),
        .wr_tag    (rs_tag),
        .wr_target (rs_target)
    );

    bpred_resolve #(.PC_W(PC_W)) u_res (
        .clk              (clk),
        .rst_n            (rst_n),
        .rs_valid         (rs_valid),
        .rs_taken         (rs_taken),
        .rs_target        (rs_target),
        .rs_pred_redirect (rs_pred_redirect),
        .rs_pred_target   (rs_pred_target),
        .res_class        (res_class),
        .mispredict       (rs_mispredict),
        .pht_we           (pht_we),
        .btb_we           (btb_we)
    );

    always_comb begin : next_pc
        lk_taken   = ctr_says_taken(lk_state);
        lk_next_pc = (lk_hit && lk_taken) ? lk_target : (lk_pc + PC_W'(4));
    end

    AST_LK_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        lk_pc[1:0] == 2'b00); // R6
    AST_RS_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        rs_valid |-> (rs_pc[1:0] == 2'b00)); // R6
    AST_REDIRECT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_next_pc != lk_pc + PC_W'(4)) |-> (lk_hit && lk_taken)); // R8
    AST_MISP_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        rs_mispredict |-> (res_class == RES_DIR_MISS || res_class == RES_TGT_MISS)); // R9

endmodule

// File: tb/sim_bpred_top.sv
module sim_bpred_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc = 32'h0;
    logic        lk_taken, lk_hit, rs_mispredict;
    logic [31:0] lk_target, lk_next_pc;
    logic        rs_valid = 1'b0;
    logic [31:0] rs_pc = 32'h0;
    logic        rs_taken = 1'b0;
    logic [31:0] rs_target = 32'h0;
    logic        rs_pred_redirect = 1'b0;
    logic [31:0] rs_pred_target = 32'h0;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    bpred_top u0 (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken), .lk_hit(lk_hit),
        .lk_target(lk_target), .lk_next_pc(lk_next_pc), .rs_valid(rs_valid), .rs_pc(rs_pc),
        .rs_taken(rs_taken), .rs_target(rs_target), .rs_pred_redirect(rs_pred_redirect),
        .rs_pred_target(rs_pred_target), .rs_mispredict(rs_mispredict)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; rs_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic look(input logic [31:0] pc);
        lk_pc = pc;
        #1;
    endtask

    // Applies one resolve on a falling edge; returns the flag sampled 1 ns later.
    // The table update lands on the following rising edge.
    task automatic resolve(input logic [31:0] pc, input bit tk, input logic [31:0] tgt,
                           input bit pr, input logic [31:0] pt, output bit misp);
        @(negedge clk);
        rs_valid = 1'b1; rs_pc = pc; rs_taken = tk; rs_target = tgt;
        rs_pred_redirect = pr; rs_pred_target = pt;
        #1 misp = rs_mispredict;
        @(negedge clk);
        rs_valid = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        look(32'h0000_0100);
        chk("R1 taken", {31'b0, lk_taken}, 32'd0);
        chk("R1 hit", {31'b0, lk_hit}, 32'd0);
        chk("R1 next", lk_next_pc, 32'h0000_0104);
    endtask

    task automatic t_hysteresis();
        bit m;
        do_reset();
        resolve(32'h80, 1'b1, 32'h400, 1'b0, 32'h0, m);
        look(32'h80); chk("R2 01->10 taken", {31'b0, lk_taken}, 32'd1);
        chk("R8 redirect", lk_next_pc, 32'h400);
        resolve(32'h80, 1'b1, 32'h400, 1'b1, 32'h400, m);
        resolve(32'h80, 1'b1, 32'h400, 1'b1, 32'h400, m);
        look(32'h80); chk("R2 saturate 11", {31'b0, lk_taken}, 32'd1);
        resolve(32'h80, 1'b0, 32'h0, 1'b1, 32'h400, m);
        look(32'h80); chk("R4 one NT keeps taken", {31'b0, lk_taken}, 32'd1);
        resolve(32'h80, 1'b0, 32'h0, 1'b1, 32'h400, m);
        look(32'h80); chk("R4 two NT flips", {31'b0, lk_taken}, 32'd0);
        chk("R8 sequential", lk_next_pc, 32'h84);
        resolve(32'h80, 1'b0, 32'h0, 1'b0, 32'h0, m);
        resolve(32'h80, 1'b0, 32'h0, 1'b0, 32'h0, m);
        resolve(32'h80, 1'b1, 32'h400, 1'b0, 32'h0, m);
        look(32'h80); chk("R3 saturate 00 then one T", {31'b0, lk_taken}, 32'd0);
    endtask

    task automatic t_alias_tag();
        bit m;
        do_reset();
        resolve(32'h100, 1'b1, 32'h900, 1'b0, 32'h0, m);
        look(32'h200);
        chk("R5 shared counter", {31'b0, lk_taken}, 32'd1);
        chk("R6 tag miss", {31'b0, lk_hit}, 32'd0);
        chk("R8 no hit no redirect", lk_next_pc, 32'h204);
        look(32'h100);
        chk("R6 tag hit", {31'b0, lk_hit}, 32'd1);
        chk("R7 target stored", lk_target, 32'h900);
        resolve(32'h100, 1'b0, 32'h0, 1'b1, 32'h900, m);
        look(32'h100);
        chk("R7 NT keeps entry", {31'b0, lk_hit}, 32'd1);
        chk("R7 NT keeps target", lk_target, 32'h900);
    endtask

    task automatic t_same_cycle();
        do_reset();
        @(negedge clk);
        lk_pc = 32'h3C;
        rs_valid = 1'b1; rs_pc = 32'h3C; rs_taken = 1'b1; rs_target = 32'hA00;
        rs_pred_redirect = 1'b0; rs_pred_target = 32'h0;
        #1;
        chk("R10 old counter", {31'b0, lk_taken}, 32'd0);
        chk("R10 old cache", {31'b0, lk_hit}, 32'd0);
        @(negedge clk);
        rs_valid = 1'b0;
        #1;
        chk("R10 new next pc", lk_next_pc, 32'hA00);
    endtask

    task automatic t_mispredict();
        bit m;
        do_reset();
        resolve(32'h40, 1'b1, 32'h500, 1'b0, 32'h0, m);
        chk("R9 taken not redirected", {31'b0, m}, 32'd1);
        resolve(32'h40, 1'b1, 32'h500, 1'b1, 32'h500, m);
        chk("R9 correct redirect", {31'b0, m}, 32'd0);
        resolve(32'h40, 1'b1, 32'h500, 1'b1, 32'h504, m);
        chk("R9 wrong target", {31'b0, m}, 32'd1);
        resolve(32'h40, 1'b0, 32'h0, 1'b1, 32'h500, m);
        chk("R9 redirected not taken", {31'b0, m}, 32'd1);
        resolve(32'h40, 1'b0, 32'h0, 1'b0, 32'h0, m);
        chk("R9 correct fallthrough", {31'b0, m}, 32'd0);
        @(negedge clk); #1;
        chk("R9 idle", {31'b0, rs_mispredict}, 32'd0);
    endtask

    // Reference model: two-bit counters and tagged cache as stated in R2-R7.
    int          m_cnt [64];
    bit          m_v   [16];
    logic [25:0] m_tag [16];
    logic [31:0] m_tgt [16];
    int          m_misp, d_misp, pred_err;

    task automatic loop_step(input logic [31:0] pc, input bit tk, input logic [31:0] tgt);
        int  pi, bi;
        bit  mp, mmis, dm, pr;
        logic [31:0] pt, mnext;
        pi = int'(pc[7:2]); bi = int'(pc[5:2]);
        mp = (m_cnt[pi] >= 2) && m_v[bi] && (m_tag[bi] == pc[31:6]);
        mnext = mp ? m_tgt[bi] : pc + 32'd4;
        look(pc);
        if (lk_next_pc !== mnext) pred_err++;
        pr = lk_hit && lk_taken; pt = lk_target;
        mmis = (tk != mp) || (tk && mp && m_tgt[bi] != tgt);
        if (mmis) m_misp++;
        resolve(pc, tk, tgt, pr, pt, dm);
        if (dm) d_misp++;
        if (tk) begin
            if (m_cnt[pi] < 3) m_cnt[pi]++;
            m_v[bi] = 1'b1; m_tag[bi] = pc[31:6]; m_tgt[bi] = tgt;
        end else if (m_cnt[pi] > 0) begin
            m_cnt[pi]--;
        end
    endtask

    task automatic t_nested_loop();
        do_reset();
        for (int i = 0; i < 64; i++) m_cnt[i] = 1;
        for (int i = 0; i < 16; i++) m_v[i] = 1'b0;
        m_misp = 0; d_misp = 0; pred_err = 0;
        for (int o = 0; o < 5; o++) begin
            for (int k = 0; k < 4; k++) loop_step(32'h40, k < 3, 32'h20);
            loop_step(32'h60, o < 4, 32'h10);
        end
        chk("R11 mispredict count", 32'(d_misp), 32'(m_misp));
        chk("R11 lookup mismatches", 32'(pred_err), 32'd0);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_hysteresis();
        t_alias_tag();
        t_same_cycle();
        t_mispredict();
        t_nested_loop();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule